// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block collects event notifications for an Ethernet MAC into a 32-bit event register, filters them through a 32-bit mask register, and presents the result as thirteen independent interrupt lines. Each interrupt line is tied to one fixed event bit. The line follows that bit ANDed with its mask bit, so software can route each source to its own interrupt input without decoding a shared status word.

Event producers such as the transmit and receive engines, the bus interface and the management port drive one-cycle pulses on a 32-bit set vector. Each pulse sets the matching event bit. Software uses a small register port. A write to the event register clears every bit written as one. A write to the mask register loads it in full. Two further addresses stand in for the management-frame and transmit-control registers. A write to either one raises its own completion event. The block does not arbitrate priority between the lines.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, the event register and the mask register read as zero and every irq_o line is low.
- R2: A one on evt_pulse_i at any of the defined event positions (bits 19 to 31) sets that event bit. The bit reads as one from the clock edge that samples the pulse onward, until software clears it.
- R3: A write to address 0 (event register) clears each event bit whose wr_data_i bit is one. Event bits written as zero keep their value.
- R4: If a pulse sets an event bit and the same bit is cleared by a write to address 0 in the same cycle, the bit ends up set.
- R5: A write to address 1 (mask register) replaces all 32 mask bits with wr_data_i. A read of address 1 returns the stored value.
- R6: irq_o[i] is high exactly when both event bit src(i) and mask bit src(i) are set. The source positions for i = 0 through 12 are 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30.
- R7: A write of any value to address 2 (management frame) sets event bit 23.
- R8: A write to address 3 (transmit control) with wr_data_i[0] = 1 sets event bit 28. The same write with wr_data_i[0] = 0 leaves the event register unchanged.
- R9: Event bits 0 to 18 always read as zero, and pulses on those positions have no effect.
- R10: Reads of addresses 2 and 3 return zero. Reads are combinational: rd_data_o follows addr_i within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address for reads and writes |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, combinational |
| evt_pulse_i | input | 32 | Event set pulses, one per event bit position |
| irq_o | output | 13 | Per-source interrupt lines |

## Verification
All register writes and event pulses take effect at the single rising edge that samples them. The interrupt lines are a combinational function of the two registers, so both rd_data_o and irq_o are due one edge after the stimulus. The bench drives every stimulus on a falling edge and holds it across exactly one rising edge. It then compares the event readback, the mask readback and the full irq_o vector on the next falling edge, after the new register values have settled. Reads are combinational, so the bench changes addr_i and samples rd_data_o a short delay later within the same cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_IRQ = 13;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_EVT   = 2'd0,
    REG_MASK  = 2'd1,
    REG_MGMT  = 2'd2,
    REG_TXCTL = 2'd3
  } reg_sel_e;

  localparam int EVB_HBEAT = 31;
  localparam int EVB_BABRX = 30;
  localparam int EVB_BABTX = 29;
  localparam int EVB_GSTOP = 28;
  localparam int EVB_TXFRM = 27;
  localparam int EVB_TXBUF = 26;
  localparam int EVB_RXFRM = 25;
  localparam int EVB_RXBUF = 24;
  localparam int EVB_MGMT  = 23;
  localparam int EVB_BUSER = 22;
  localparam int EVB_LCOL  = 21;
  localparam int EVB_RETRY = 20;
  localparam int EVB_UNDR  = 19;

  // irq line index -> event bit
  function automatic int irq_src_bit(input int idx);
    case (idx)
      0:       return EVB_TXFRM;
      1:       return EVB_TXBUF;
      2:       return EVB_UNDR;
      3:       return EVB_RETRY;
      4:       return EVB_RXFRM;
      5:       return EVB_RXBUF;
      6:       return EVB_MGMT;
      7:       return EVB_LCOL;
      8:       return EVB_HBEAT;
      9:       return EVB_GSTOP;
      10:      return EVB_BUSER;
      11:      return EVB_BABTX;
      default: return EVB_BABRX;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] defined_bits();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_IRQ; i++) m[irq_src_bit(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] EVT_DEF_MASK = defined_bits();
endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
  import evt_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] clr_o,
  output logic [DW-1:0] sw_set_o,
  output logic          mask_we_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    clr_o     = '0;
    sw_set_o  = '0;
    mask_we_o = 1'b0;
    if (wr_en_i) begin
      unique case (sel)
        REG_EVT:   clr_o = wr_data_i;
        REG_MASK:  mask_we_o = 1'b1;
        REG_MGMT:  sw_set_o[EVB_MGMT] = 1'b1;
        REG_TXCTL: sw_set_o[EVB_GSTOP] = wr_data_i[0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
  import evt_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter logic [DW-1:0] DEF = EVT_DEF_MASK
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] evt_o
);
  logic [DW-1:0] evt_q, set_m;
  assign set_m = set_i & DEF;

  // set takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (evt_q & ~clr_i & DEF) | set_m;
  end
  assign evt_o = evt_q;

  a_r2_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & $past(set_i & DEF)) == $past(set_i & DEF)));
  a_r3_clear_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & $past(clr_i & ~set_i)) == '0));
  a_r3_untouched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & ~$past(clr_i | set_i)) == ($past(evt_q) & ~$past(clr_i | set_i))));
  a_r9_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q & ~DEF) == '0);
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask
  import evt_irq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= data_i;
  end
  assign mask_o = mask_q;

  a_r5_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mask_q == $past(data_i)));
  a_r5_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_q));
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route
  import evt_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NI = NUM_IRQ
) (
  input  logic [DW-1:0] evt_i,
  input  logic [DW-1:0] mask_i,
  output logic [NI-1:0] irq_o
);
  for (genvar g = 0; g < NI; g++) begin : g_line
    localparam int SRC = irq_src_bit(g);
    assign irq_o[g] = evt_i[SRC] & mask_i[SRC];
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NI = NUM_IRQ
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [DW-1:0] evt_pulse_i,
  output logic [NI-1:0] irq_o
);
  logic [DW-1:0] clr, sw_set, evt, mask;
  logic          mask_we;

  evt_irq_decode #(.DW(DW), .AW(AW)) u_decode (
    .addr_i, .wr_en_i, .wr_data_i,
    .clr_o(clr), .sw_set_o(sw_set), .mask_we_o(mask_we)
  );

  evt_irq_status #(.DW(DW)) u_status (
    .clk_i, .rst_ni,
    .set_i(evt_pulse_i | sw_set), .clr_i(clr), .evt_o(evt)
  );

  evt_irq_mask #(.DW(DW)) u_mask (
    .clk_i, .rst_ni, .we_i(mask_we), .data_i(wr_data_i), .mask_o(mask)
  );

  evt_irq_route #(.DW(DW), .NI(NI)) u_route (
    .evt_i(evt), .mask_i(mask), .irq_o
  );

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_EVT:  rd_data_o = evt;
      REG_MASK: rd_data_o = mask;
      default:  rd_data_o = '0;
    endcase
  end

  a_r6_irq_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) == $countones(evt & mask));
  a_r7_mgmt_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_MGMT) |=> evt[EVB_MGMT]);
  a_r8_gstop_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_TXCTL && wr_data_i[0]) |=> evt[EVB_GSTOP]);
  a_r1_idle_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0));
endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pulse = '0;
  logic [12:0] irq;

  int vectors = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] m_evt = '0, m_mask = '0;

  always #2 clk = ~clk;

  evt_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wr_data_i(wdata), .rd_data_o(rdata), .evt_pulse_i(pulse), .irq_o(irq)
  );

  localparam int SRC [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
  localparam logic [31:0] DEF = 32'hFFF8_0000;

  function automatic logic [12:0] exp_irq(logic [31:0] e, logic [31:0] m);
    logic [12:0] r;
    for (int i = 0; i < 13; i++) r[i] = e[SRC[i]] & m[SRC[i]];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  // full state check: event, mask, irq
  task automatic chk_all(string req);
    logic [31:0] v;
    rd(2'd0, v); chk({req, " evt"}, v, m_evt);
    rd(2'd1, v); chk({req, " mask"}, v, m_mask);
    chk({req, " irq"}, {19'd0, irq}, {19'd0, exp_irq(m_evt, m_mask)});
  endtask

  // drive on falling edge, hold through one rising edge
  task automatic cyc(logic w, logic [1:0] a, logic [31:0] d, logic [31:0] p);
    @(negedge clk);
    we = w; addr = a; wdata = d; pulse = p;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; pulse = '0; wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    // R1 during reset
    repeat (3) @(negedge clk);
    chk("R1 rst irq", {19'd0, irq}, '0);
    rd(2'd0, v); chk("R1 rst evt", v, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // R2/R9 each bit position, with full mask, then R3 clear
    cyc(1'b1, 2'd1, 32'hFFFF_FFFF, '0);
    m_mask = 32'hFFFF_FFFF;
    for (int b = 0; b < 32; b++) begin
      cyc(1'b0, 2'd0, '0, 32'd1 << b);
      m_evt = m_evt | ((32'd1 << b) & DEF);
      chk_all(b < 19 ? "R9" : "R2");
      cyc(1'b1, 2'd0, 32'd1 << b, '0);
      m_evt = m_evt & ~(32'd1 << b);
      chk_all("R3");
    end

    // R6 each line alone: all events set, one mask bit
    cyc(1'b0, 2'd0, '0, 32'hFFFF_FFFF);
    m_evt = DEF;
    for (int i = 0; i < 13; i++) begin
      cyc(1'b1, 2'd1, 32'd1 << SRC[i], '0);
      m_mask = 32'd1 << SRC[i];
      chk("R6 line", {19'd0, irq}, 32'd1 << i);
      chk_all("R6");
    end

    // R5 mask patterns
    for (int k = 0; k < 8; k++) begin
      logic [31:0] pat;
      pat = 32'h9E37_79B9 * (k + 1) ^ (32'h5A5A_0F0F >> k);
      cyc(1'b1, 2'd1, pat, '0);
      m_mask = pat;
      chk_all("R5");
    end

    // R3 partial clear: zeros keep bits
    cyc(1'b1, 2'd0, 32'hA5A0_0000, '0);
    m_evt = m_evt & ~32'hA5A0_0000;
    chk_all("R3 partial");

    // R4 set beats clear
    cyc(1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0810_0000);
    m_evt = 32'h0810_0000;
    chk_all("R4");

    // R7 management write
    cyc(1'b1, 2'd0, 32'hFFFF_FFFF, '0);
    m_evt = '0;
    cyc(1'b1, 2'd2, 32'h0000_1234, '0);
    m_evt[23] = 1'b1;
    chk_all("R7");

    // R8 txctl bit0 = 0 no effect, = 1 sets
    cyc(1'b1, 2'd3, 32'hFFFF_FFFE, '0);
    chk_all("R8 bit0 low");
    cyc(1'b1, 2'd3, 32'h0000_0001, '0);
    m_evt[28] = 1'b1;
    chk_all("R8");

    // R10 reads of 2 and 3
    rd(2'd2, v); chk("R10 addr2", v, '0);
    rd(2'd3, v); chk("R10 addr3", v, '0);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_evt = '0; m_mask = '0;
    chk_all("R1 async");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule